// File: doc/BRIEF.md
# Multidrop Receiver Sleep and Wakeup Controller

This block sits beside the receive core of a serial port whose line is shared by several receivers. When software decides that the message in progress is meant for another node, it writes the sleep bit to 1. From then on the block gates off every receiver status flag, so the node is not interrupted by the rest of that message. Software never has to clear the bit in normal use: the block clears it by itself as soon as the next message starts.

A single mode bit selects how a new message is recognised. In idle-line mode, a new message is the first idle detection on the line after at least one character has arrived. This relies on the sender leaving no gap between the characters of a message and at least one idle frame between messages. In address-mark mode, a new message starts with a character whose most significant bit is 1. That character wakes the node and is delivered with its status flags, so software can inspect the address it carries. Address matching is left to software.

The receive core supplies a character-complete strobe with the character's MSB, an idle-detect strobe, and the raw set requests of its five status flags. The block returns the gated set requests, the inhibit signal and the two register bits.

Top module: `rx_wake_ctl`

## Requirements
- R1: After a synchronous reset, sleep is 0, mode is 0, flag_inhibit is 0, and no character is counted as seen since the last idle detection.
- R2: A cycle with sw_wr high loads sw_sleep into sleep and sw_mode into mode, visible on the following cycle; writing sleep to 0 wakes the receiver.
- R3: While sleep is 1, flag_inhibit is 1 and flag_set is all zeros, except in the cycle covered by R7.
- R4: While sleep is 0, flag_inhibit is 0 and flag_set equals flag_req bit for bit.
- R5: In idle-line mode (mode = 0), an idle_det pulse while asleep clears sleep on the next cycle if a character_done pulse occurred after the previous idle_det (or after reset); in that idle_det cycle all flags, including the idle flag, stay suppressed.
- R6: In idle-line mode, an idle_det pulse with no character since the previous idle_det or reset leaves sleep at 1.
- R7: In address-mark mode (mode = 1), a char_done pulse with char_msb = 1 while asleep clears sleep on the next cycle, and in that same cycle flag_inhibit is 0 and flag_set equals flag_req.
- R8: In address-mark mode, a character with char_msb = 0 or an idle_det pulse leaves sleep at 1.
- R9: In idle-line mode, a character with char_msb = 1 does not wake the receiver.
- R10: When a hardware wakeup and a software write of sleep = 1 occur in the same cycle, sleep becomes 0.
- R11: Flag bit positions are fixed: bit 0 data-full, bit 1 idle, bit 2 overrun, bit 3 noise, bit 4 framing error; the gating keeps each bit in its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe for the control bits |
| sw_sleep | input | 1 | Sleep value to write |
| sw_mode | input | 1 | Wakeup method to write: 0 idle-line, 1 address-mark |
| char_done | input | 1 | Character-complete strobe from the receive core |
| char_msb | input | 1 | MSB of the completed character |
| idle_det | input | 1 | Idle-line detect strobe from the receive core |
| flag_req | input | NFLAG | Raw status-flag set requests |
| sleep | output | 1 | Current sleep bit |
| mode | output | 1 | Current wakeup method bit |
| flag_inhibit | output | 1 | High when status flags must not be set |
| flag_set | output | NFLAG | Gated status-flag set requests |

## Verification
A stuck or wrong sleep bit shows up on the next cycle. It either passes flags through that should be blocked or blocks them when they should pass, and the sleep output disagrees with the value the event history predicts. If the memory of a character since the last idle were wrong, the fault would stay hidden until the next idle_det pulse. At that point the node would either wake without having seen a character or stay asleep through the gap between messages. This is why every wake case is swept both with and without a prior character. A wrong release of the inhibit in address-mark mode is visible in the same cycle as the waking character, through flag_set.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    localparam int NUM_FLAGS  = 5;
    localparam int FLG_FULL   = 0;
    localparam int FLG_IDLE   = 1;
    localparam int FLG_OVRN   = 2;
    localparam int FLG_NOISE  = 3;
    localparam int FLG_FRAME  = 4;

    typedef struct packed {
        logic done;
        logic msb;
    } char_evt_t;

    typedef struct packed {
        logic       wr;
        logic       sleep;
        wake_mode_e mode;
    } sw_cmd_t;

    function automatic logic is_addr_mark(input wake_mode_e m, input char_evt_t c);
        return (m == WAKE_ADDR) && c.done && c.msb;
    endfunction

    function automatic logic is_idle_wake(input wake_mode_e m, input logic idle, input logic armed);
        return (m == WAKE_IDLE) && idle && armed;
    endfunction

endpackage

// File: rtl/wk_arm_track.sv
module wk_arm_track
    import wk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  char_evt_t chr,
    input  logic      idle_det,
    output logic      armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (chr.done) begin
            armed_q <= 1'b1;
        end else if (idle_det) begin
            armed_q <= 1'b0;
        end
    end

    assign armed = armed_q;
endmodule

// File: rtl/wk_wake_logic.sv
module wk_wake_logic
    import wk_pkg::*;
(
    input  logic       sleep_q,
    input  wake_mode_e mode_q,
    input  char_evt_t  chr,
    input  logic       idle_det,
    input  logic       armed,
    output logic       hw_wake,
    output logic       inhibit
);
    logic addr_hit;
    logic idle_hit;

    always_comb begin
        addr_hit = is_addr_mark(mode_q, chr);
        idle_hit = is_idle_wake(mode_q, idle_det, armed);
        hw_wake  = sleep_q && (addr_hit || idle_hit);
        inhibit  = sleep_q && !addr_hit;
    end
endmodule

// File: rtl/wk_ctrl_reg.sv
module wk_ctrl_reg
    import wk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sw_cmd_t    cmd,
    input  logic       hw_wake,
    output logic       sleep_q,
    output wake_mode_e mode_q
);
    logic       sleep_d;
    wake_mode_e mode_d;

    always_comb begin
        sleep_d = sleep_q;
        mode_d  = mode_q;
        if (cmd.wr) begin
            sleep_d = cmd.sleep;
            mode_d  = cmd.mode;
        end
        if (hw_wake) begin
            sleep_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
            mode_q  <= WAKE_IDLE;
        end else begin
            sleep_q <= sleep_d;
            mode_q  <= mode_d;
        end
    end
endmodule

// File: rtl/wk_flag_gate.sv
module wk_flag_gate #(
    parameter int NFLAG = 5
) (
    input  logic             inhibit,
    input  logic [NFLAG-1:0] req,
    output logic [NFLAG-1:0] set
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_gate
        assign set[i] = req[i] & ~inhibit;
    end
endmodule

// File: rtl/rx_wake_ctl.sv
module rx_wake_ctl
    import wk_pkg::*;
#(
    parameter int NFLAG = wk_pkg::NUM_FLAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr,
    input  logic             sw_sleep,
    input  logic             sw_mode,
    input  logic             char_done,
    input  logic             char_msb,
    input  logic             idle_det,
    input  logic [NFLAG-1:0] flag_req,
    output logic             sleep,
    output logic             mode,
    output logic             flag_inhibit,
    output logic [NFLAG-1:0] flag_set
);
    char_evt_t  chr;
    sw_cmd_t    cmd;
    logic       armed_q;
    logic       hw_wake;
    logic       inhibit;
    logic       sleep_q;
    wake_mode_e mode_q;

    assign chr.done  = char_done;
    assign chr.msb   = char_msb;
    assign cmd.wr    = sw_wr;
    assign cmd.sleep = sw_sleep;
    assign cmd.mode  = wake_mode_e'(sw_mode);

    wk_arm_track u_arm (
        .clk      (clk),
        .rst      (rst),
        .chr      (chr),
        .idle_det (idle_det),
        .armed    (armed_q)
    );

    wk_wake_logic u_wake (
        .sleep_q  (sleep_q),
        .mode_q   (mode_q),
        .chr      (chr),
        .idle_det (idle_det),
        .armed    (armed_q),
        .hw_wake  (hw_wake),
        .inhibit  (inhibit)
    );

    wk_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .hw_wake (hw_wake),
        .sleep_q (sleep_q),
        .mode_q  (mode_q)
    );

    wk_flag_gate #(.NFLAG(NFLAG)) u_gate (
        .inhibit (inhibit),
        .req     (flag_req),
        .set     (flag_set)
    );

    assign sleep        = sleep_q;
    assign mode         = mode_q;
    assign flag_inhibit = inhibit;
endmodule

// File: rtl/wk_checker.sv
module wk_checker #(
    parameter int NFLAG = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_wr,
    input logic             sw_sleep,
    input logic             char_done,
    input logic             char_msb,
    input logic             idle_det,
    input logic [NFLAG-1:0] flag_req,
    input logic             sleep,
    input logic             mode,
    input logic             flag_inhibit,
    input logic [NFLAG-1:0] flag_set,
    input logic             armed
);
    // R3: asleep and no address mark -> nothing gets through
    assert_sleep_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (sleep && !(mode && char_done && char_msb)) |-> (flag_set == '0 && flag_inhibit));

    // R4: awake -> flags pass unchanged
    assert_awake_pass_R4: assert property (@(posedge clk) disable iff (rst)
        !sleep |-> (flag_set == flag_req && !flag_inhibit));

    // R5: armed idle detection wakes in idle-line mode, idle flag held off
    assert_idle_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode && sleep && idle_det && armed) |-> (flag_set == '0) ##1 !sleep);

    // R6: unarmed idle detection keeps sleeping
    assert_idle_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode && sleep && !armed && !(sw_wr && !sw_sleep)) |=> sleep);

    // R7 and R10: address mark wakes even against a software write of 1
    assert_addr_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (mode && sleep && char_done && char_msb) |-> (!flag_inhibit && flag_set == flag_req) ##1 !sleep);

    // R8: in address-mark mode other events keep sleeping
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode && sleep && !(char_done && char_msb) && !(sw_wr && !sw_sleep)) |=> sleep);
endmodule

bind rx_wake_ctl wk_checker #(.NFLAG(NFLAG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_wr        (sw_wr),
    .sw_sleep     (sw_sleep),
    .char_done    (char_done),
    .char_msb     (char_msb),
    .idle_det     (idle_det),
    .flag_req     (flag_req),
    .sleep        (sleep),
    .mode         (mode),
    .flag_inhibit (flag_inhibit),
    .flag_set     (flag_set),
    .armed        (armed_q)
);

// File: tb/sim_rx_wake_ctl.sv
`timescale 1ns/1ps
module sim_rx_wake_ctl;
    localparam int NF = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sw_wr = 1'b0, sw_sleep = 1'b0, sw_mode = 1'b0;
    logic          char_done = 1'b0, char_msb = 1'b0, idle_det = 1'b0;
    logic [NF-1:0] flag_req = '0;
    logic          sleep, mode, flag_inhibit;
    logic [NF-1:0] flag_set;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    rx_wake_ctl #(.NFLAG(NF)) u0 (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_sleep(sw_sleep), .sw_mode(sw_mode),
        .char_done(char_done), .char_msb(char_msb), .idle_det(idle_det),
        .flag_req(flag_req), .sleep(sleep), .mode(mode),
        .flag_inhibit(flag_inhibit), .flag_set(flag_set)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        sw_wr = 0; sw_sleep = 0; sw_mode = 0;
        char_done = 0; char_msb = 0; idle_det = 0; flag_req = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); clear_in(); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
    endtask

    // one cycle: inputs set at negedge, combinational checks by caller after #1
    task automatic write_ctl(input logic s, input logic m);
        @(negedge clk); sw_wr = 1; sw_sleep = s; sw_mode = m;
        @(posedge clk); @(negedge clk); sw_wr = 0;
    endtask

    task automatic send_char(input logic msb);
        @(negedge clk); char_done = 1; char_msb = msb;
        @(posedge clk); @(negedge clk); char_done = 0; char_msb = 0;
    endtask

    task automatic pulse_idle();
        @(negedge clk); idle_det = 1;
        @(posedge clk); @(negedge clk); idle_det = 0;
    endtask

    initial begin
        do_reset();
        #1;
        chk("R1 sleep", sleep, 0);
        chk("R1 mode", mode, 0);
        chk("R1 inhibit", flag_inhibit, 0);
        // R1: no character seen -> idle_det after sleeping does not wake
        write_ctl(1, 0);
        pulse_idle(); #1;
        chk("R1 not armed", sleep, 1);

        // R4 / R11: awake pass-through, all patterns, each bit in place
        do_reset();
        for (int p = 0; p < 32; p++) begin
            @(negedge clk); flag_req = p[NF-1:0]; #1;
            chk("R4 R11 pass", {flag_inhibit, flag_set}, {1'b0, p[4:0]});
        end
        flag_req = '0;

        // R2: write 1 then 0, and mode readback
        write_ctl(1, 1); #1;
        chk("R2 sleep set", sleep, 1);
        chk("R2 mode set", mode, 1);
        @(negedge clk); flag_req = 5'h1F; #1;
        chk("R3 blocked", {flag_inhibit, flag_set}, {1'b1, 5'h00});
        flag_req = '0;
        write_ctl(0, 0); #1;
        chk("R2 sleep cleared", sleep, 0);
        chk("R2 mode cleared", mode, 0);

        // R6 then R5: idle-line sequence
        do_reset();
        write_ctl(1, 0);
        pulse_idle(); #1;
        chk("R6 unarmed idle", sleep, 1);
        pulse_idle(); #1;
        chk("R6 second idle", sleep, 1);
        send_char(1); #1;
        chk("R9 msb1 in idle mode", sleep, 1);
        @(negedge clk); idle_det = 1; flag_req = 5'h1F; #1;
        chk("R5 idle flag held", flag_set[1], 0);
        @(posedge clk); @(negedge clk); idle_det = 0; flag_req = 5'h1F; #1;
        chk("R5 woke", sleep, 0);
        chk("R5 flags pass after wake", flag_set, 5'h1F);
        flag_req = '0;

        // Sweep: method x prior char x {idle, char, msb, sw write 1}
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int ev = 0; ev < 16; ev++) begin
                    logic e_idle, e_cd, e_msb, e_sw, wake;
                    logic [NF-1:0] exp_f;
                    string tag;
                    e_idle = ev[0]; e_cd = ev[1]; e_msb = ev[2]; e_sw = ev[3];
                    wake = (m == 1) ? (e_cd && e_msb) : (e_idle && (a == 1));
                    exp_f = (m == 1 && e_cd && e_msb) ? 5'h1F : 5'h00;
                    if (m == 1) tag = wake ? (e_sw ? "R10 addr" : "R7 addr") : "R8 addr";
                    else        tag = wake ? (e_sw ? "R10 idle" : "R5 idle")
                                           : (a == 1 ? "R9 idle" : "R6 idle");
                    do_reset();
                    write_ctl(1, m[0]);
                    if (a == 1) begin
                        @(negedge clk); char_done = 1; char_msb = 0; flag_req = 5'h1F; #1;
                        chk("R3 msb0 char asleep", flag_set, 5'h00);
                        @(posedge clk); @(negedge clk); char_done = 0; flag_req = '0;
                    end
                    @(negedge clk);
                    idle_det = e_idle; char_done = e_cd; char_msb = e_msb;
                    sw_wr = e_sw; sw_sleep = 1; sw_mode = m[0]; flag_req = 5'h1F; #1;
                    chk({tag, " flags"}, flag_set, exp_f);
                    @(posedge clk); @(negedge clk);
                    clear_in(); #1;
                    chk({tag, " sleep"}, sleep, !wake);
                    chk({tag, " mode kept"}, mode, m[0]);
                end
            end
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule